// File: doc/BRIEF.md
# Row-Buffered EEPROM Write Controller

This block sits between a CPU-side byte bus and a small on-chip data EEPROM, modelled here as a behavioural byte array. Plain bus reads of the storage window return array contents. To change the array, software first sets a latch-enable bit in a control register. Each byte it then writes to the window goes into one of 32 write-only row-buffer latches, selected by the low five address bits. A byte written twice into the same latch is AND-merged with the value already there.

Software then sets a program-start bit. The block runs a timed programming cycle and commits the buffered bytes into the row named by the upper address bits of the most recent buffered write. Only latches that were written replace array bytes. All other bytes of that row keep their old values. When the timer expires, hardware clears both control bits in the same clock and empties the buffer. Software can also discard a session by clearing latch-enable.

The default array is 256 bytes, which is 8 rows of 32 bytes. Read data is registered and appears one clock after the read request.

Top module: `eep_row_writer`

## Requirements
- R1: After reset the control register reads 0, `busy` is 0, and every array byte reads 0xFF.
- R2: A bus access with `bus_ctl`=1 targets the control register. Bit 0 is latch-enable and bit 1 is program-start. A read returns {6'b0, program-start, latch-enable} one clock after the request, and a write of bit 0 sets or clears latch-enable.
- R3: While latch-enable is 0, writes to the storage window (`bus_ctl`=0) change nothing, and window reads return the array byte at `bus_addr`, one clock after the request.
- R4: While latch-enable is 1 and no cycle runs, a window write stores its byte into latch `bus_addr[4:0]`. Window reads still return array contents and never buffered data.
- R5: A second write to an already written latch in the same session leaves the bitwise AND of the old latched value and the new byte.
- R6: A control write with bits 1 and 0 both set, issued while latch-enable is already 1, starts a programming cycle. `busy` goes high in the next clock and stays high for exactly PROG_CYCLES clocks. A program-start bit written while latch-enable was 0 is ignored.
- R7: The cycle writes each written latch into the row `bus_addr[7:5]` of the last buffered write, at the column equal to its latch index. Array bytes of unwritten columns keep their values.
- R8: At the end of the cycle, latch-enable and program-start both read 0 and `busy` falls, all in the same clock.
- R9: The buffer is emptied at the end of every cycle and when a control write clears latch-enable. A later write to the same latch then stores its byte unmerged, and a cycle with no buffered writes leaves the array unchanged.
- R10: While `busy` is 1, window writes and all control writes are ignored, and window reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctl | input | 1 | 1 = control register, 0 = storage window |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid one clock after a read |
| busy | output | 1 | High for the whole programming cycle |

## Verification
Damage to the latch valid mask or the captured row does not show up until the commit. It appears as wrong bytes in a row that is read back after `busy` falls, in columns that were never written or in the wrong row. An error in the timer or in the control-bit clearing appears at once, because `busy` and the control register read back the wrong value in the very clock it happens. For that reason the reference model is compared on every clock, and every commit is followed by reads of the written row and of neighbouring bytes.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CTL_LAT_BIT  = 0;
  localparam int CTL_PROG_BIT = 1;
endpackage

// File: rtl/eep_row_latch.sv
module eep_row_latch #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  row_q
);
  localparam int NCOL = 1 << COL_W;

  logic [DATA_W-1:0] lat_d [NCOL];
  logic [NCOL-1:0]   lat_v;

  for (genvar g = 0; g < NCOL; g++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lat_v[g] <= 1'b0;
        lat_d[g] <= '0;
      end else if (wr_en && (wr_col == COL_W'(g))) begin
        lat_v[g] <= 1'b1;
        lat_d[g] <= lat_v[g] ? (lat_d[g] & wr_data) : wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        row_q <= '0;
    else if (wr_en) row_q <= wr_row;
  end

  assign rd_data  = lat_d[rd_col];
  assign rd_valid = lat_v[rd_col];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (lat_v == '0)); // R9
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 64,
  parameter int COL_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [COL_W-1:0] idx,
  output logic             act,
  output logic             done
);
  localparam int NCOL  = 1 << COL_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == CNT_W'(PROG_CYCLES - 1));
  assign act  = run && (cnt < CNT_W'(NCOL));
  assign idx  = cnt[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CNT_W'(PROG_CYCLES))); // R6
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[raddr];
  end
endmodule

// File: rtl/eep_row_writer.sv
module eep_row_writer #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int COL_W       = 5,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_ctl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy
);
  import eep_pkg::*;
  localparam int ROW_W = ADDR_W - COL_W;

  logic lat_q, prog_q;
  logic ctl_wr, lat_wr, start, lat_fall, clear;
  logic rd_req, mem_re, mem_we;
  logic [COL_W-1:0]  idx;
  logic              act, done;
  logic [DATA_W-1:0] lch_data, mem_q;
  logic              lch_valid;
  logic [ROW_W-1:0]  row_q;
  logic              rsel_ctl, rblank;
  logic [DATA_W-1:0] ctl_snap;

  assign ctl_wr   = bus_en && bus_we && bus_ctl && !prog_q;
  assign lat_wr   = bus_en && bus_we && !bus_ctl && lat_q && !prog_q;
  assign start    = ctl_wr && lat_q && bus_wdata[CTL_LAT_BIT] && bus_wdata[CTL_PROG_BIT];
  assign lat_fall = ctl_wr && lat_q && !bus_wdata[CTL_LAT_BIT];
  assign clear    = done || lat_fall;
  assign rd_req   = bus_en && !bus_we;
  assign mem_re   = rd_req && !bus_ctl && !prog_q;
  assign mem_we   = act && lch_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= 1'b0;
      prog_q <= 1'b0;
    end else if (done) begin
      lat_q  <= 1'b0;
      prog_q <= 1'b0;
    end else if (ctl_wr) begin
      lat_q <= bus_wdata[CTL_LAT_BIT];
      if (start) prog_q <= 1'b1;
    end
  end

  eep_row_latch #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) i_latch (
    .clk(clk), .rst(rst), .wr_en(lat_wr),
    .wr_col(bus_addr[COL_W-1:0]), .wr_row(bus_addr[ADDR_W-1:COL_W]),
    .wr_data(bus_wdata), .clear(clear), .rd_col(idx),
    .rd_data(lch_data), .rd_valid(lch_valid), .row_q(row_q)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .COL_W(COL_W)) i_timer (
    .clk(clk), .rst(rst), .run(prog_q), .idx(idx), .act(act), .done(done)
  );

  eep_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst(rst), .we(mem_we), .waddr({row_q, idx}), .wdata(lch_data),
    .re(mem_re), .raddr(bus_addr), .rq(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_ctl <= 1'b1;
      rblank   <= 1'b0;
      ctl_snap <= '0;
    end else if (rd_req) begin
      rsel_ctl <= bus_ctl;
      rblank   <= prog_q;
      ctl_snap <= '0;
      ctl_snap[CTL_LAT_BIT]  <= lat_q;
      ctl_snap[CTL_PROG_BIT] <= prog_q;
    end
  end

  assign bus_rdata = rsel_ctl ? ctl_snap : (rblank ? '1 : mem_q);
  assign busy      = prog_q;

  AST_PROG_NEEDS_LAT: assert property (@(posedge clk) disable iff (rst)
    prog_q |-> lat_q); // R6
  AST_START_FROM_LAT: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_q) |-> $past(lat_q)); // R6
  AST_DONE_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
    done |=> (!lat_q && !prog_q)); // R8
  AST_BUSY_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !bus_ctl && prog_q) |=> (bus_rdata == '1)); // R10
  AST_ROW_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    prog_q |=> $stable(row_q)); // R10
  AST_COMMIT_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> prog_q); // R7
endmodule

// File: tb/test_eep_row_writer.sv
module test_eep_row_writer;
  localparam int PROG = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0, bus_ctl = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       busy;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state
  int m_mem [256];
  int m_lat [32];
  bit m_val [32];
  int m_row = 0;
  bit m_le = 0, m_pg = 0;
  int m_cnt = 0;
  int m_rdata = 0;

  always #10 clk = ~clk;

  eep_row_writer #(.PROG_CYCLES(PROG)) i_eep_row_writer (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_ctl(bus_ctl),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  initial for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;

  task automatic m_clear();
    for (int i = 0; i < 32; i++) begin m_val[i] = 0; m_lat[i] = 0; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_le = 0; m_pg = 0; m_cnt = 0; m_rdata = 0; m_row = 0; m_clear();
    end else begin
      bit old_le;
      old_le = m_le;
      if (bus_en && !bus_we)
        m_rdata = bus_ctl ? ((m_pg ? 2 : 0) + (m_le ? 1 : 0))
                          : (m_pg ? 8'hFF : m_mem[bus_addr]);
      if (m_pg) begin
        if (m_cnt < 32 && m_val[m_cnt]) m_mem[m_row * 32 + m_cnt] = m_lat[m_cnt];
        if (m_cnt == PROG - 1) begin
          m_pg = 0; m_le = 0; m_cnt = 0; m_clear();
        end else m_cnt++;
      end else if (bus_en && bus_we) begin
        if (bus_ctl) begin
          if (old_le && !bus_wdata[0]) m_clear();
          if (old_le && bus_wdata[0] && bus_wdata[1]) begin m_pg = 1; m_cnt = 0; end
          m_le = bus_wdata[0];
        end else if (m_le) begin
          int c;
          c = bus_addr[4:0];
          m_lat[c] = m_val[c] ? (m_lat[c] & bus_wdata) : bus_wdata;
          m_val[c] = 1;
          m_row = bus_addr[7:5];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy !== m_pg) begin
        errors++;
        $display("FAIL %s busy actual %0b expected %0b", cur_req, busy, m_pg);
      end
      checks++;
      if (bus_rdata !== 8'(m_rdata)) begin
        errors++;
        $display("FAIL %s rdata actual %02h expected %02h", cur_req, bus_rdata, m_rdata);
      end
    end
  end

  task automatic wr(input bit ctl, input int a, input int d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_ctl = ctl; bus_addr = 8'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input bit ctl, input int a, input int exp);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_ctl = ctl; bus_addr = 8'(a);
    @(negedge clk);
    bus_en = 0;
    #1;
    checks++;
    if (bus_rdata !== 8'(exp)) begin
      errors++;
      $display("FAIL %s read %0s[%02h] actual %02h expected %02h",
               cur_req, ctl ? "ctl" : "mem", a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog expired", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    rd(1, 0, 0); rd(0, 8'h00, 8'hFF); rd(0, 8'hFF, 8'hFF);
    cur_req = "R3";
    wr(0, 8'h05, 8'h12); rd(0, 8'h05, 8'hFF);
    cur_req = "R2";
    wr(1, 0, 1); rd(1, 0, 1);
    cur_req = "R4";
    wr(0, 8'h23, 8'h5A); rd(0, 8'h23, 8'hFF);
    cur_req = "R5";
    wr(0, 8'h23, 8'h0F);
    cur_req = "R7";
    wr(0, 8'h40, 8'h11); wr(0, 8'h61, 8'h77);
    cur_req = "R6";
    wr(1, 0, 3); idle(1);
    cur_req = "R10";
    wr(0, 8'h62, 8'h00); wr(1, 0, 0); rd(0, 8'h61, 8'hFF); rd(1, 0, 3);
    idle(PROG);
    cur_req = "R8";
    rd(1, 0, 0);
    cur_req = "R7";
    rd(0, 8'h60, 8'h11); rd(0, 8'h61, 8'h77); rd(0, 8'h62, 8'hFF);
    rd(0, 8'h40, 8'hFF);
    cur_req = "R5";
    rd(0, 8'h63, 8'h0A);
    cur_req = "R9";
    wr(1, 0, 1); wr(0, 8'h64, 8'hF0); wr(1, 0, 0); wr(1, 0, 1);
    wr(0, 8'h64, 8'h0F); wr(1, 0, 3); idle(PROG + 2);
    rd(0, 8'h64, 8'h0F);
    wr(1, 0, 1); wr(1, 0, 3); idle(PROG + 2);
    rd(0, 8'h64, 8'h0F); rd(1, 0, 0);
    cur_req = "R6";
    wr(1, 0, 2); rd(1, 0, 0); wr(1, 0, 3); rd(1, 0, 1); wr(1, 0, 0);
    cur_req = "R7";
    for (int k = 0; k < 6; k++) begin
      wr(1, 0, 1);
      for (int j = 0; j < 6; j++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
        wr(0, (seed >> 8) & 8'hFF, (seed >> 16) & 8'hFF);
      end
      wr(1, 0, 3); idle(PROG + 1);
      for (int j = 0; j < 32; j++) begin
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_ctl = 0; bus_addr = 8'(m_row * 32 + j);
      end
      @(negedge clk); bus_en = 0;
    end
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule